// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one column command into the run of column addresses that a synchronous DRAM burst visits, one address per clock. A command gives a start column, a length code, an ordering choice and a read or write flag. The block then steps through the burst. Fixed-length bursts stay inside an aligned block whose size is the burst length, and they can step in either counting or XOR order. Full-page bursts count upward through the whole page, wrapping at the end, until a stop request arrives.

A controller places the block beside its command path. It pulses `cmd_go` with each read or write and `cmd_stop` for a burst terminate. It takes `col_out` while `col_vld` is high. A new command always takes over at once, even in the middle of a burst. `col_last` marks the final address of a fixed burst. When write-single mode is set, write commands visit only one location.

Top module: `sdr_col_seq`

## Requirements
- R1: After a synchronous reset, `col_vld` and `col_last` are 0 and stay 0 until a command is accepted.
- R2: A command sampled on a rising edge makes `col_vld` 1 after that edge, with `col_out` equal to the start column, for every length and ordering.
- R3: `len_sel` sets the burst length: 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats, 3 gives 8 beats and 7 gives full page. Codes 4, 5 and 6 act as 1 beat. A fixed burst keeps `col_vld` high for exactly that many cycles.
- R4: During a fixed burst of length BL, the bits of `col_out` above the low log2(BL) bits keep the value they have in the start column.
- R5: With `ilv_sel`=0, beat i of a fixed burst has low bits (start + i) mod BL.
- R6: With `ilv_sel`=1, beat i of a fixed burst has low bits start XOR i.
- R7: In full-page mode, `col_out` rises by one each cycle modulo 2^COL_W, whatever the value of `ilv_sel`. It continues until stopped.
- R8: `col_last` is 1 on the final beat of a fixed burst only. It is never 1 in full-page mode.
- R9: When `wr_single`=1, a command with `cmd_wr`=1 produces exactly one beat, with `col_last` set. A command with `cmd_wr`=0 still uses the length from `len_sel`.
- R10: `cmd_stop` without `cmd_go` makes `col_vld` 0 from the next edge. While the block is idle it has no effect.
- R11: A new command during a burst restarts the sequence at its own start column on the next edge. When `cmd_go` and `cmd_stop` arrive together, the command wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Accept a read or write command this cycle |
| cmd_wr | input | 1 | 1 for a write command, 0 for a read |
| start_col | input | COL_W | Start column of the command |
| len_sel | input | 3 | Burst length code (see R3) |
| ilv_sel | input | 1 | 1 selects XOR order for fixed bursts |
| wr_single | input | 1 | 1 limits write commands to one location |
| cmd_stop | input | 1 | Burst terminate request |
| col_out | output | COL_W | Current column address |
| col_vld | output | 1 | `col_out` holds a burst beat |
| col_last | output | 1 | Final beat of a fixed burst |

## Verification
The bench runs every length code with both orderings across many start columns, including starts near the top of the page. A design that let a carry leak past the block would show up here as a wrong upper field (R4). A design that added where it should XOR would give the wrong order for odd starts (R6).

Full-page runs start two columns below the top of the page, with XOR order selected, to catch a design that fails to wrap or that lets the ordering choice affect full page. The bench also checks that `col_last` never rises in full page. Other cases cover:
- a write in single mode, which catches a design that ignores the mode or applies it to reads;
- a stop while idle and a stop mid-burst;
- a command arriving during a burst;
- a command and a stop arriving in the same cycle, which catches a design that gives the stop priority.

// File: rtl/sdr_col_pkg.sv
package sdr_col_pkg;

    localparam logic [2:0] LEN_ONE   = 3'd0;
    localparam logic [2:0] LEN_TWO   = 3'd1;
    localparam logic [2:0] LEN_FOUR  = 3'd2;
    localparam logic [2:0] LEN_EIGHT = 3'd3;
    localparam logic [2:0] LEN_PAGE  = 3'd7;

    // Decoded burst shape held for the length of a burst
    typedef struct packed {
        logic       full;   // full-page counting burst
        logic       ilv;    // XOR ordering within the block
        logic [1:0] lg;     // log2 of fixed burst length
    } burst_mode_t;

    // Low-bit mask of a fixed burst block
    function automatic logic [3:0] blk_mask(input logic [1:0] lg);
        return 4'((5'd1 << lg) - 5'd1);
    endfunction

endpackage

// File: rtl/sdr_col_mode_dec.sv
module sdr_col_mode_dec
    import sdr_col_pkg::*;
(
    input  logic [2:0]  len_sel,
    input  logic        ilv_sel,
    input  logic        is_wr,
    input  logic        wr_single,
    output burst_mode_t mode
);

    always_comb begin
        mode     = '0;
        mode.ilv = ilv_sel;
        case (len_sel)
            LEN_TWO:   mode.lg = 2'd1;
            LEN_FOUR:  mode.lg = 2'd2;
            LEN_EIGHT: mode.lg = 2'd3;
            LEN_PAGE:  mode.full = 1'b1;
            default:   mode.lg = 2'd0;
        endcase
        if (is_wr && wr_single) begin
            mode.full = 1'b0;
            mode.lg   = 2'd0;
        end
        if (mode.full) begin
            mode.ilv = 1'b0;
        end
    end

    always_comb begin
        a_r7_page_is_seq: assert (!(mode.full && mode.ilv));
        a_r9_single_write: assert (!(is_wr && wr_single) || (!mode.full && mode.lg == 2'd0));
    end

endmodule

// File: rtl/sdr_col_addr.sv
module sdr_col_addr
    import sdr_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             vld,
    input  burst_mode_t      mode,
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    output logic [COL_W-1:0] col,
    output logic [COL_W-1:0] mask,
    output logic             last
);

    localparam int PAD_W = COL_W - 4;

    logic [COL_W-1:0] seq_c;
    logic [COL_W-1:0] xor_c;
    logic [COL_W-1:0] low_c;

    always_comb begin
        mask  = mode.full ? '1 : {{PAD_W{1'b0}}, blk_mask(mode.lg)};
        seq_c = base + idx;
        xor_c = base ^ idx;
        low_c = mode.ilv ? xor_c : seq_c;
        col   = (base & ~mask) | (low_c & mask);
        last  = vld && !mode.full && (idx == mask);
    end

    always_comb begin
        a_r4_idx_in_block: assert (!vld || mode.full || ((idx & ~mask) == '0));
    end

endmodule

// File: rtl/sdr_col_seq.sv
module sdr_col_seq
    import sdr_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_go,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_sel,
    input  logic             ilv_sel,
    input  logic             wr_single,
    input  logic             cmd_stop,
    output logic [COL_W-1:0] col_out,
    output logic             col_vld,
    output logic             col_last
);

    typedef struct packed {
        logic             vld;
        burst_mode_t      mode;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] idx;
    } seq_state_t;

    seq_state_t       st;
    burst_mode_t      new_mode;
    logic [COL_W-1:0] cur_mask;
    logic             at_last;

    sdr_col_mode_dec u_dec (
        .len_sel   (len_sel),
        .ilv_sel   (ilv_sel),
        .is_wr     (cmd_wr),
        .wr_single (wr_single),
        .mode      (new_mode)
    );

    sdr_col_addr #(.COL_W(COL_W)) u_addr (
        .vld  (st.vld),
        .mode (st.mode),
        .base (st.base),
        .idx  (st.idx),
        .col  (col_out),
        .mask (cur_mask),
        .last (at_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (cmd_go) begin
            st.vld  <= 1'b1;
            st.mode <= new_mode;
            st.base <= start_col;
            st.idx  <= '0;
        end else if (cmd_stop) begin
            st.vld <= 1'b0;
        end else if (st.vld) begin
            if (at_last) begin
                st.vld <= 1'b0;
            end else begin
                st.idx <= st.idx + 1'b1;
            end
        end
    end

    assign col_vld  = st.vld;
    assign col_last = at_last;

    a_r2_first_beat: assert property (@(posedge clk) disable iff (rst)
        cmd_go |=> (col_vld && col_out == $past(start_col)));

    a_r4_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        (col_vld && !st.mode.full && !col_last && !cmd_go && !cmd_stop)
        |=> (((col_out ^ $past(col_out)) & ~$past(cur_mask)) == '0));

    a_r7_page_count: assert property (@(posedge clk) disable iff (rst)
        (col_vld && st.mode.full && !cmd_go && !cmd_stop)
        |=> (col_vld && col_out == COL_W'($past(col_out) + 1'b1)));

    a_r8_no_last_page: assert property (@(posedge clk) disable iff (rst)
        (col_vld && st.mode.full) |-> !col_last);

    a_r8_last_ends: assert property (@(posedge clk) disable iff (rst)
        (col_last && !cmd_go) |=> !col_vld);

    a_r10_stop_drops: assert property (@(posedge clk) disable iff (rst)
        (cmd_stop && !cmd_go) |=> !col_vld);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !col_vld |-> !col_last);

endmodule

// File: tb/sdr_col_seq_test.sv
module sdr_col_seq_test;

    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst;
    logic             cmd_go, cmd_wr, ilv_sel, wr_single, cmd_stop;
    logic [COL_W-1:0] start_col;
    logic [2:0]       len_sel;
    logic [COL_W-1:0] col_out;
    logic             col_vld, col_last;

    int checks = 0;
    int bad    = 0;

    always #10 clk = ~clk;

    sdr_col_seq #(.COL_W(COL_W)) uut (
        .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_wr(cmd_wr),
        .start_col(start_col), .len_sel(len_sel), .ilv_sel(ilv_sel),
        .wr_single(wr_single), .cmd_stop(cmd_stop),
        .col_out(col_out), .col_vld(col_vld), .col_last(col_last)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int len_log(input int code);
        case (code)
            1: return 1;
            2: return 2;
            3: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_col(input int s, input int lg, input int ilv, input int i);
        int m;
        int lo;
        m  = (1 << lg) - 1;
        lo = ilv ? ((s ^ i) & m) : ((s + i) & m);
        return (s & ~m) | lo;
    endfunction

    task automatic issue(input int s, input int len, input int ilv, input int wr, input int single);
        cmd_go    = 1'b1;
        start_col = COL_W'(s);
        len_sel   = 3'(len);
        ilv_sel   = ilv[0];
        cmd_wr    = wr[0];
        wr_single = single[0];
        tick();
        cmd_go = 1'b0;
    endtask

    // R3 R5 R6 R8 R9: full fixed burst, then idle
    task automatic run_fixed(input int s, input int len, input int ilv, input int wr, input int single);
        int lg;
        int n;
        lg = (wr != 0 && single != 0) ? 0 : len_log(len);
        n  = 1 << lg;
        issue(s, len, ilv, wr, single);
        for (int i = 0; i < n; i++) begin
            chk("R3 valid", int'(col_vld), 1);
            chk(ilv ? "R6 order" : "R5 order", int'(col_out), exp_col(s, lg, ilv, i));
            chk("R8 last", int'(col_last), (i == n - 1) ? 1 : 0);
            tick();
        end
        chk("R3 burst end", int'(col_vld), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_go = 1'b0; cmd_wr = 1'b0; ilv_sel = 1'b0;
        wr_single = 1'b0; cmd_stop = 1'b0; start_col = '0; len_sel = '0;
        tick(); tick();
        rst = 1'b0;
        tick();
        chk("R1 reset vld", int'(col_vld), 0);
        chk("R1 reset last", int'(col_last), 0);

        // R10: stop while idle
        cmd_stop = 1'b1;
        tick(); tick();
        cmd_stop = 1'b0;
        chk("R10 idle stop", int'(col_vld), 0);

        // R2 R3 R4 R5 R6 R8 sweep: all length codes except page, both orders
        for (int len = 0; len < 7; len++)
            for (int ilv = 0; ilv < 2; ilv++)
                for (int s = 0; s < 512; s += 7)
                    run_fixed(s, len, ilv, 0, 0);
        run_fixed(511, 3, 1, 0, 0);
        run_fixed(511, 3, 0, 0, 0);

        // R9: single write vs read and vs write without mode
        run_fixed(45, 3, 0, 1, 1);
        run_fixed(45, 3, 0, 0, 1);
        run_fixed(45, 3, 1, 1, 0);

        // R7 R8: full page wrap with ilv set, then stop (R10)
        issue(510, 7, 1, 0, 0);
        for (int i = 0; i < 20; i++) begin
            chk("R7 page col", int'(col_out), (510 + i) % 512);
            chk("R7 page valid", int'(col_vld), 1);
            chk("R8 page no last", int'(col_last), 0);
            tick();
        end
        cmd_stop = 1'b1;
        tick();
        cmd_stop = 1'b0;
        chk("R10 page stop", int'(col_vld), 0);
        tick();
        chk("R10 stays idle", int'(col_vld), 0);

        // R10: stop mid fixed burst
        issue(0, 3, 0, 0, 0);
        tick(); tick();
        cmd_stop = 1'b1;
        tick();
        cmd_stop = 1'b0;
        chk("R10 mid stop", int'(col_vld), 0);

        // R11: restart during a burst
        issue(16, 3, 0, 0, 0);
        chk("R11 first", int'(col_out), 16);
        tick();
        chk("R11 second", int'(col_out), 17);
        issue(37, 1, 1, 0, 0);
        chk("R11 restart col", int'(col_out), 37);
        chk("R11 restart last", int'(col_last), 0);
        tick();
        chk("R11 restart beat2", int'(col_out), 36);
        chk("R11 restart beat2 last", int'(col_last), 1);
        tick();
        chk("R11 restart end", int'(col_vld), 0);

        // R11: go and stop together, go wins
        issue(100, 3, 0, 0, 0);
        tick();
        cmd_stop = 1'b1;
        issue(3, 0, 0, 0, 0);
        cmd_stop = 1'b0;
        chk("R11 go beats stop vld", int'(col_vld), 1);
        chk("R11 go beats stop col", int'(col_out), 3);
        chk("R11 go beats stop last", int'(col_last), 1);
        tick();
        chk("R11 single end", int'(col_vld), 0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule